// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the fifteen general registers of a processor core (index 0 to 14; the program counter is kept elsewhere) together with per-mode shadow copies. Registers 0 to 7 are always shared. A fast-interrupt bank keeps private copies of registers 8 to 14. Every other privileged bank keeps private copies of registers 13 and 14 only. Codes that match no mode land in a dummy bank that has no storage. A mode-change strobe swaps the live registers with the shadow copies in a single clock edge.

Beside the read and write ports for the active mode, a side port reaches the register of any mode by code. The block also holds the current status word and one saved status word for each bank that has one. A status write carries a four-bit byte mask, and unprivileged modes may only update the top byte. Instruction decode, exception sequencing, the program counter and pipeline flushing are left to the surrounding core.

Top module: `mbrf_top`

## Requirements
- R1: Mode codes select banks as follows: 0x00, 0x10 and 0x1F use the user bank; 0x01 and 0x11 use the fast-interrupt bank; 0x02 and 0x12 use the interrupt bank; 0x03 and 0x13 use the supervisor bank; 0x17 uses the abort bank; 0x1B uses the undefined bank; every other code uses the dummy bank.
- R2: After reset the mode is 0x13, every register and every shadow copy reads zero, the status word reads 0x00000013 and every saved status word is zero.
- R3: The active read port returns register 0 to 14 combinationally. A write is visible on the next cycle. Address 15 reads zero, and writes to it are dropped.
- R4: A mode-change strobe loads the new code into the mode output on the next edge. Registers 0 to 7 are unaffected. Registers 13 and 14 are saved to the old bank's copy and loaded from the new bank's copy.
- R5: The fast-interrupt bank keeps registers 8 to 14 private. Entering it saves the user values of 8 to 12, and leaving it restores them.
- R6: The interrupt, supervisor, abort, undefined and user banks share registers 8 to 12.
- R7: Entering the dummy bank sets registers 8 to 14 to zero. Values written there are lost on exit. The user values of 8 to 12 and the old bank's 13 and 14 are preserved.
- R8: A mode change between two codes of the same bank (for example 0x10, 0x1F and 0x00) moves no register.
- R9: In a cycle carrying a mode-change strobe, both the active write and the side write are dropped.
- R10: A side access to a mode whose bank is the active bank uses the live registers, and registers 0 to 7 are always live. Any other access uses that bank's copy (for 8 to 12 in a non-fast bank, that is the user copy). A dummy target reads zero and ignores writes. If both ports write the same live register in one cycle, the active port wins.
- R11: The fast-interrupt, interrupt, supervisor, abort and undefined banks each hold a saved status word. Reading it in any other bank returns the current status word, and writing it there changes nothing.
- R12: Status mask bit 0 covers bits 7:5 (bits 4:0 always show the mode), bit 1 covers 15:8, bit 2 covers 23:16 and bit 3 covers 31:24. In modes 0x10 and 0x00 only bit 3 takes effect on the current word. A saved write updates all 8 bits of each selected byte. Status writes are visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_chg_i | input | 1 | Mode-change strobe |
| mode_new_i | input | 5 | Mode code to switch to |
| mode_o | output | 5 | Current mode code |
| rd_addr_i | input | 4 | Active-mode read index |
| rd_data_o | output | 32 | Active-mode read data |
| wr_en_i | input | 1 | Active-mode write enable |
| wr_addr_i | input | 4 | Active-mode write index |
| wr_data_i | input | 32 | Active-mode write data |
| side_we_i | input | 1 | Side-port write enable |
| side_mode_i | input | 5 | Mode code targeted by the side port |
| side_addr_i | input | 4 | Side-port register index |
| side_wdata_i | input | 32 | Side-port write data |
| side_rdata_o | output | 32 | Side-port read data |
| psw_we_i | input | 1 | Status write enable |
| psw_saved_i | input | 1 | 1 selects the saved word, 0 the current word |
| psw_mask_i | input | 4 | Byte mask for the status write |
| psw_wdata_i | input | 32 | Status write data |
| psr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status word of the current bank, or the current word |

## Verification
All three read paths are combinational. The bench sets an index and compares a nanosecond later, away from any edge. Register writes, status writes and mode changes take effect at the first rising edge after they are driven. Every check on them is made one nanosecond after that edge, once the strobe has been dropped. The bench walks through all 32 mode codes and compares every active register and every side-port cell in all 32 modes against a bank model. This checks the swap on the edge itself rather than some cycles later.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;
   localparam int MODE_W = 5;
   localparam int NBANK  = 7;
   localparam int FIELDS = 4;

   typedef enum logic [2:0] {
      BK_USR = 3'd0,
      BK_FIQ = 3'd1,
      BK_IRQ = 3'd2,
      BK_SVC = 3'd3,
      BK_ABT = 3'd4,
      BK_UND = 3'd5,
      BK_DMY = 3'd6
   } bank_e;

   // banks whose registers 8..12 are not the user copies
   function automatic logic owns_hi(bank_e b);
      return (b == BK_FIQ) || (b == BK_DMY);
   endfunction

   function automatic logic has_saved(bank_e b);
      return (b != BK_USR) && (b != BK_DMY);
   endfunction

   function automatic logic is_unpriv(logic [MODE_W-1:0] m);
      return (m == 5'h10) || (m == 5'h00);
   endfunction
endpackage

// File: rtl/mbrf_mode_map.sv
module mbrf_mode_map
   import mbrf_pkg::*;
(
   input  logic [MODE_W-1:0] mode_i,
   output bank_e             bank_o
);
   always_comb begin
      case (mode_i)
         5'h00, 5'h10, 5'h1F: bank_o = BK_USR;
         5'h01, 5'h11:        bank_o = BK_FIQ;
         5'h02, 5'h12:        bank_o = BK_IRQ;
         5'h03, 5'h13:        bank_o = BK_SVC;
         5'h17:               bank_o = BK_ABT;
         5'h1B:               bank_o = BK_UND;
         default:             bank_o = BK_DMY;
      endcase
   end
endmodule

// File: rtl/mbrf_psr.sv
module mbrf_psr
   import mbrf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  bank_e             bank_i,
   input  logic              we_i,
   input  logic              saved_i,
   input  logic [FIELDS-1:0] mask_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] psr_o,
   output logic [DATA_W-1:0] spsr_o
);
   localparam int BYTE_W = DATA_W / FIELDS;

   logic [DATA_W-1:MODE_W] cur_q;
   logic [DATA_W-1:0]      sav_q [NBANK];
   logic [FIELDS-1:0]      cur_fld;
   logic [FIELDS-1:0]      sav_fld;
   logic [DATA_W-1:MODE_W] cur_bm;
   logic [DATA_W-1:0]      sav_bm;
   logic                   unpriv;
   logic                   sav_ok;

   assign unpriv = is_unpriv(mode_i);
   assign sav_ok = has_saved(bank_i);

   genvar f;
   generate
      for (f = 0; f < FIELDS; f++) begin : g_fld
         assign cur_fld[f] = we_i && !saved_i && mask_i[f] && (!unpriv || (f == FIELDS-1));
         assign sav_fld[f] = we_i && saved_i && mask_i[f] && sav_ok;
         assign sav_bm[f*BYTE_W +: BYTE_W] = {BYTE_W{sav_fld[f]}};
         if (f == 0) begin : g_low
            // low byte: mode bits are owned by the mode register
            assign cur_bm[BYTE_W-1:MODE_W] = {(BYTE_W-MODE_W){cur_fld[f]}};
         end else begin : g_full
            assign cur_bm[f*BYTE_W +: BYTE_W] = {BYTE_W{cur_fld[f]}};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         for (int b = 0; b < NBANK; b++) sav_q[b] <= '0;
      end else begin
         cur_q <= (cur_q & ~cur_bm) | (wdata_i[DATA_W-1:MODE_W] & cur_bm);
         if (|sav_fld) sav_q[bank_i] <= (sav_q[bank_i] & ~sav_bm) | (wdata_i & sav_bm);
      end
   end

   assign psr_o  = {cur_q, mode_i};
   assign spsr_o = sav_ok ? sav_q[bank_i] : psr_o;
endmodule

// File: rtl/mbrf_top.sv
module mbrf_top
   import mbrf_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          NREG       = 15,
   parameter logic [4:0]  RESET_MODE = 5'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_chg_i,
   input  logic [4:0]        mode_new_i,
   output logic [4:0]        mode_o,
   input  logic [3:0]        rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              wr_en_i,
   input  logic [3:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              side_we_i,
   input  logic [4:0]        side_mode_i,
   input  logic [3:0]        side_addr_i,
   input  logic [DATA_W-1:0] side_wdata_i,
   output logic [DATA_W-1:0] side_rdata_o,
   input  logic              psw_we_i,
   input  logic              psw_saved_i,
   input  logic [3:0]        psw_mask_i,
   input  logic [DATA_W-1:0] psw_wdata_i,
   output logic [DATA_W-1:0] psr_o,
   output logic [DATA_W-1:0] spsr_o
);
   localparam int ADDR_W = 4;
   localparam int LR_IDX = NREG - 1;
   localparam int SP_IDX = NREG - 2;
   localparam int HI_LO  = NREG - 7;
   localparam int HI_CNT = SP_IDX - HI_LO;

   generate
      if (DATA_W != 8 * FIELDS) begin : g_bad_width
         $error("mbrf_top: DATA_W must be eight bits per status field");
      end
      if (NREG < 9 || NREG > 15) begin : g_bad_nreg
         $error("mbrf_top: NREG must be between 9 and 15");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;
   bank_e             cur_bank, new_bank, side_bank;

   logic [DATA_W-1:0] live_q [NREG];
   logic [DATA_W-1:0] live_d [NREG];
   logic [DATA_W-1:0] usr_q  [HI_CNT];
   logic [DATA_W-1:0] usr_d  [HI_CNT];
   logic [DATA_W-1:0] fiq_q  [HI_CNT];
   logic [DATA_W-1:0] fiq_d  [HI_CNT];
   logic [DATA_W-1:0] sp_q   [NBANK];
   logic [DATA_W-1:0] sp_d   [NBANK];
   logic [DATA_W-1:0] lr_q   [NBANK];
   logic [DATA_W-1:0] lr_d   [NBANK];

   logic [ADDR_W-1:0] side_hi;
   logic              side_ok, wr_ok, bank_move;

   mbrf_mode_map u_map_cur  (.mode_i(mode_q),      .bank_o(cur_bank));
   mbrf_mode_map u_map_new  (.mode_i(mode_new_i),  .bank_o(new_bank));
   mbrf_mode_map u_map_side (.mode_i(side_mode_i), .bank_o(side_bank));

   assign side_hi   = side_addr_i - ADDR_W'(HI_LO);
   assign side_ok   = side_addr_i < ADDR_W'(NREG);
   assign wr_ok     = wr_en_i && !mode_chg_i && (wr_addr_i < ADDR_W'(NREG));
   assign bank_move = mode_chg_i && (new_bank != cur_bank);

   // next-state of the register storage
   always_comb begin
      live_d = live_q;
      usr_d  = usr_q;
      fiq_d  = fiq_q;
      sp_d   = sp_q;
      lr_d   = lr_q;
      if (bank_move) begin
         // save side
         if (cur_bank == BK_FIQ)
            for (int k = 0; k < HI_CNT; k++) fiq_d[k] = live_q[HI_LO+k];
         if (!owns_hi(cur_bank) && owns_hi(new_bank))
            for (int k = 0; k < HI_CNT; k++) usr_d[k] = live_q[HI_LO+k];
         if (cur_bank != BK_DMY) begin
            sp_d[cur_bank] = live_q[SP_IDX];
            lr_d[cur_bank] = live_q[LR_IDX];
         end
         // restore side
         if (new_bank == BK_DMY) begin
            for (int k = HI_LO; k < NREG; k++) live_d[k] = '0;
         end else begin
            if (new_bank == BK_FIQ)
               for (int k = 0; k < HI_CNT; k++) live_d[HI_LO+k] = fiq_q[k];
            else if (owns_hi(cur_bank))
               for (int k = 0; k < HI_CNT; k++) live_d[HI_LO+k] = usr_q[k];
            live_d[SP_IDX] = sp_q[new_bank];
            live_d[LR_IDX] = lr_q[new_bank];
         end
      end else if (!mode_chg_i) begin
         if (side_we_i && side_ok) begin
            if (side_bank == cur_bank || side_addr_i < ADDR_W'(HI_LO))
               live_d[side_addr_i] = side_wdata_i;
            else if (side_bank != BK_DMY) begin
               if (side_addr_i == ADDR_W'(SP_IDX))      sp_d[side_bank] = side_wdata_i;
               else if (side_addr_i == ADDR_W'(LR_IDX)) lr_d[side_bank] = side_wdata_i;
               else if (side_bank == BK_FIQ)            fiq_d[side_hi] = side_wdata_i;
               else if (owns_hi(cur_bank))              usr_d[side_hi] = side_wdata_i;
               else                                     live_d[side_addr_i] = side_wdata_i;
            end
         end
         // active port is applied last so it wins a clash
         if (wr_ok) live_d[wr_addr_i] = wr_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= RESET_MODE;
         for (int i = 0; i < NREG; i++)   live_q[i] <= '0;
         for (int i = 0; i < HI_CNT; i++) begin usr_q[i] <= '0; fiq_q[i] <= '0; end
         for (int i = 0; i < NBANK; i++)  begin sp_q[i] <= '0;  lr_q[i] <= '0;  end
      end else begin
         if (mode_chg_i) mode_q <= mode_new_i;
         live_q <= live_d;
         usr_q  <= usr_d;
         fiq_q  <= fiq_d;
         sp_q   <= sp_d;
         lr_q   <= lr_d;
      end
   end

   // read paths
   assign rd_data_o = (rd_addr_i < ADDR_W'(NREG)) ? live_q[rd_addr_i] : '0;

   always_comb begin
      if (!side_ok)
         side_rdata_o = '0;
      else if (side_bank == cur_bank || side_addr_i < ADDR_W'(HI_LO))
         side_rdata_o = live_q[side_addr_i];
      else if (side_bank == BK_DMY)
         side_rdata_o = '0;
      else if (side_addr_i == ADDR_W'(SP_IDX))
         side_rdata_o = sp_q[side_bank];
      else if (side_addr_i == ADDR_W'(LR_IDX))
         side_rdata_o = lr_q[side_bank];
      else if (side_bank == BK_FIQ)
         side_rdata_o = fiq_q[side_hi];
      else if (owns_hi(cur_bank))
         side_rdata_o = usr_q[side_hi];
      else
         side_rdata_o = live_q[side_addr_i];
   end

   assign mode_o = mode_q;

   mbrf_psr #(.DATA_W(DATA_W)) u_psr (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (mode_q),
      .bank_i  (cur_bank),
      .we_i    (psw_we_i),
      .saved_i (psw_saved_i),
      .mask_i  (psw_mask_i),
      .wdata_i (psw_wdata_i),
      .psr_o   (psr_o),
      .spsr_o  (spsr_o)
   );
endmodule

// File: rtl/mbrf_chk.sv
module mbrf_chk
   import mbrf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NREG   = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_chg_i,
   input logic [4:0]        mode_new_i,
   input logic [4:0]        mode_o,
   input bank_e             cur_bank,
   input bank_e             new_bank,
   input logic [3:0]        rd_addr_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              wr_en_i,
   input logic [3:0]        wr_addr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic              psw_we_i,
   input logic              psw_saved_i,
   input logic [DATA_W-1:0] psr_o,
   input logic [DATA_W-1:0] spsr_o
);
   localparam int HI_LO = NREG - 7;

   AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg_i |=> (mode_o == $past(mode_new_i)));  // R4

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en_i && !mode_chg_i && (wr_addr_i < 4'(NREG))) && (rd_addr_i == $past(wr_addr_i)))
      |-> (rd_data_o == $past(wr_data_i)));  // R3

   AST_DUMMY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_chg_i && (new_bank != cur_bank)) && (cur_bank == BK_DMY) &&
       (rd_addr_i >= 4'(HI_LO)) && (rd_addr_i < 4'(NREG)))
      |-> (rd_data_o == '0));  // R7

   AST_SAME_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_chg_i && (new_bank == cur_bank)) && (rd_addr_i == $past(rd_addr_i)))
      |-> (rd_data_o == $past(rd_data_o)));  // R8

   AST_SAVED_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      !has_saved(cur_bank) |-> (spsr_o == psr_o));  // R11

   AST_UNPRIV_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (psw_we_i && !psw_saved_i && is_unpriv(mode_o))
      |=> (psr_o[DATA_W-9:MODE_W] == $past(psr_o[DATA_W-9:MODE_W])));  // R12
endmodule

bind mbrf_top mbrf_chk #(.DATA_W(DATA_W), .NREG(NREG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_chg_i  (mode_chg_i),
   .mode_new_i  (mode_new_i),
   .mode_o      (mode_o),
   .cur_bank    (cur_bank),
   .new_bank    (new_bank),
   .rd_addr_i   (rd_addr_i),
   .rd_data_o   (rd_data_o),
   .wr_en_i     (wr_en_i),
   .wr_addr_i   (wr_addr_i),
   .wr_data_i   (wr_data_i),
   .psw_we_i    (psw_we_i),
   .psw_saved_i (psw_saved_i),
   .psr_o       (psr_o),
   .spsr_o      (spsr_o)
);

// File: tb/tb_mbrf_top.sv
`timescale 1ns/1ps
module tb_mbrf_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_chg_i = 1'b0;
   logic [4:0]  mode_new_i = '0;
   logic [4:0]  mode_o;
   logic [3:0]  rd_addr_i = '0;
   logic [31:0] rd_data_o;
   logic        wr_en_i = 1'b0;
   logic [3:0]  wr_addr_i = '0;
   logic [31:0] wr_data_i = '0;
   logic        side_we_i = 1'b0;
   logic [4:0]  side_mode_i = '0;
   logic [3:0]  side_addr_i = '0;
   logic [31:0] side_wdata_i = '0;
   logic [31:0] side_rdata_o;
   logic        psw_we_i = 1'b0;
   logic        psw_saved_i = 1'b0;
   logic [3:0]  psw_mask_i = '0;
   logic [31:0] psw_wdata_i = '0;
   logic [31:0] psr_o;
   logic [31:0] spsr_o;

   always #10 clk = ~clk;

   mbrf_top dut (.*);

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // bank model
   logic [31:0] ml  [15];
   logic [31:0] mu  [5];
   logic [31:0] mf  [5];
   logic [31:0] msp [7];
   logic [31:0] mlr [7];
   logic [31:0] msv [7];
   logic [31:0] mhi;
   logic [4:0]  mmode;

   function automatic int bk(input logic [4:0] m);
      case (m)
         5'h00, 5'h10, 5'h1F: return 0;
         5'h01, 5'h11:        return 1;
         5'h02, 5'h12:        return 2;
         5'h03, 5'h13:        return 3;
         5'h17:               return 4;
         5'h1B:               return 5;
         default:             return 6;
      endcase
   endfunction

   function automatic bit own(input int b);
      return (b == 1) || (b == 6);
   endfunction

   function automatic logic [31:0] exp_psr();
      return {mhi[31:5], mmode};
   endfunction

   function automatic logic [31:0] exp_spsr();
      int b = bk(mmode);
      return (b != 0 && b != 6) ? msv[b] : exp_psr();
   endfunction

   function automatic logic [31:0] exp_side(input logic [4:0] m, input int a);
      int b  = bk(m);
      int cb = bk(mmode);
      if (a >= 15) return 32'h0;
      if (b == cb || a < 8) return ml[a];
      if (b == 6) return 32'h0;
      if (a == 13) return msp[b];
      if (a == 14) return mlr[b];
      if (b == 1) return mf[a-8];
      if (own(cb)) return mu[a-8];
      return ml[a];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic mdl_chg(input logic [4:0] nm);
      int ob = bk(mmode);
      int nb = bk(nm);
      if (ob != nb) begin
         if (ob == 1) for (int k = 0; k < 5; k++) mf[k] = ml[8+k];
         if (!own(ob) && own(nb)) for (int k = 0; k < 5; k++) mu[k] = ml[8+k];
         if (ob != 6) begin msp[ob] = ml[13]; mlr[ob] = ml[14]; end
         if (nb == 6) for (int k = 8; k < 15; k++) ml[k] = 32'h0;
         else begin
            if (nb == 1) for (int k = 0; k < 5; k++) ml[8+k] = mf[k];
            else if (own(ob)) for (int k = 0; k < 5; k++) ml[8+k] = mu[k];
            ml[13] = msp[nb];
            ml[14] = mlr[nb];
         end
      end
      mmode = nm;
   endtask

   task automatic mdl_side(input logic [4:0] m, input int a, input logic [31:0] d);
      int b  = bk(m);
      int cb = bk(mmode);
      if (a >= 15) return;
      if (b == cb || a < 8) ml[a] = d;
      else if (b != 6) begin
         if (a == 13) msp[b] = d;
         else if (a == 14) mlr[b] = d;
         else if (b == 1) mf[a-8] = d;
         else if (own(cb)) mu[a-8] = d;
         else ml[a] = d;
      end
   endtask

   task automatic do_chg(input logic [4:0] nm);
      mode_chg_i = 1'b1; mode_new_i = nm;
      tick();
      mode_chg_i = 1'b0;
      mdl_chg(nm);
      chk("R4 mode output", {27'h0, mode_o}, {27'h0, nm});
   endtask

   task automatic do_wr(input int a, input logic [31:0] d);
      wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = d;
      tick();
      wr_en_i = 1'b0;
      if (a < 15) ml[a] = d;
   endtask

   task automatic do_side(input logic [4:0] m, input int a, input logic [31:0] d);
      side_we_i = 1'b1; side_mode_i = m; side_addr_i = 4'(a); side_wdata_i = d;
      tick();
      side_we_i = 1'b0;
      mdl_side(m, a, d);
   endtask

   task automatic do_psw(input bit sv, input logic [3:0] mask, input logic [31:0] d);
      int b = bk(mmode);
      psw_we_i = 1'b1; psw_saved_i = sv; psw_mask_i = mask; psw_wdata_i = d;
      tick();
      psw_we_i = 1'b0;
      for (int f = 0; f < 4; f++) begin
         if (mask[f]) begin
            if (!sv && (f == 3 || !(mmode == 5'h10 || mmode == 5'h00)))
               mhi[f*8 +: 8] = d[f*8 +: 8];
            if (sv && b != 0 && b != 6)
               msv[b][f*8 +: 8] = d[f*8 +: 8];
         end
      end
   endtask

   task automatic check_all(input string reg_tag);
      for (int r = 0; r < 16; r++) begin
         rd_addr_i = 4'(r);
         #1;
         chk(r == 15 ? "R3 address 15" : reg_tag, rd_data_o, r < 15 ? ml[r] : 32'h0);
      end
      for (int m = 0; m < 32; m++) begin
         for (int a = 0; a < 16; a++) begin
            side_mode_i = 5'(m); side_addr_i = 4'(a);
            #1;
            chk("R10 side read (R1 bank map)", side_rdata_o, exp_side(5'(m), a));
         end
      end
      chk("R11 saved status read", spsr_o, exp_spsr());
      chk("R12 current status", psr_o, exp_psr());
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      for (int i = 0; i < 15; i++) ml[i] = '0;
      for (int i = 0; i < 5; i++) begin mu[i] = '0; mf[i] = '0; end
      for (int i = 0; i < 7; i++) begin msp[i] = '0; mlr[i] = '0; msv[i] = '0; end
      mhi = '0;
      mmode = 5'h13;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;
      // R2: reset state
      chk("R2 reset mode", {27'h0, mode_o}, 32'h13);
      chk("R2 reset status", psr_o, 32'h0000_0013);
      chk("R2 reset saved status", spsr_o, 32'h0);
      check_all("R2 reset register");

      // R3: fill all registers in supervisor mode
      for (int r = 0; r < 16; r++) do_wr(r, 32'h5300_0000 | r);
      check_all("R3 write then read");

      // R1/R4/R5/R6/R7: walk through every mode code
      for (int m = 0; m < 32; m++) begin
         int b;
         do_chg(5'(m));
         b = bk(5'(m));
         check_all(b == 6 ? "R7 dummy bank regs" : (b == 1 ? "R5 fast bank regs" : "R6 shared regs"));
         for (int r = 0; r < 15; r++) do_wr(r, 32'hC000_0000 | (m << 8) | r);
      end
      do_chg(5'h10);
      check_all("R7 values after leaving dummy");

      // R8: same-bank switches move nothing
      do_wr(13, 32'h1313_0D0D);
      do_chg(5'h1F);
      check_all("R8 user to system");
      do_chg(5'h00);
      check_all("R8 system to old user code");

      // R5: fast bank round trip
      do_chg(5'h11);
      for (int r = 8; r < 15; r++) do_wr(r, 32'hF1F0_0000 | r);
      do_chg(5'h12);
      check_all("R5 user copies back after leaving fast bank");
      do_chg(5'h11);
      check_all("R5 fast copies back on re-entry");

      // R9: writes dropped in a mode-change cycle
      mode_chg_i = 1'b1; mode_new_i = 5'h13;
      wr_en_i = 1'b1; wr_addr_i = 4'd2; wr_data_i = 32'hDEAD_0002;
      side_we_i = 1'b1; side_mode_i = 5'h11; side_addr_i = 4'd5; side_wdata_i = 32'hDEAD_0005;
      tick();
      mode_chg_i = 1'b0; wr_en_i = 1'b0; side_we_i = 1'b0;
      mdl_chg(5'h13);
      check_all("R9 writes dropped during change");

      // R10: side writes into other banks and a clash with the active port
      do_side(5'h11, 9,  32'hA011_0009);
      do_side(5'h11, 13, 32'hA011_000D);
      do_side(5'h12, 14, 32'hA012_000E);
      do_side(5'h10, 10, 32'hA010_000A);
      do_side(5'h1B, 13, 32'hA01B_000D);
      do_side(5'h05, 11, 32'hA005_000B);
      do_side(5'h1F, 3,  32'hA01F_0003);
      check_all("R10 side writes from supervisor");
      do_chg(5'h01);
      do_side(5'h17, 12, 32'hA017_000C);
      do_side(5'h00, 8,  32'hA000_0008);
      check_all("R10 side writes from fast bank");
      side_we_i = 1'b1; side_mode_i = 5'h01; side_addr_i = 4'd3; side_wdata_i = 32'hBBBB_0003;
      wr_en_i = 1'b1; wr_addr_i = 4'd3; wr_data_i = 32'hAAAA_0003;
      tick();
      side_we_i = 1'b0; wr_en_i = 1'b0;
      ml[3] = 32'hAAAA_0003;
      check_all("R10 active port wins clash");

      // R12: masked status writes, privileged
      do_chg(5'h13);
      for (int k = 0; k < 16; k++) begin
         do_psw(1'b0, 4'(k), 32'h1111_1111 * k + 32'h0F0F_00E0);
         chk("R12 privileged masked write", psr_o, exp_psr());
      end
      // R12: unprivileged only flags byte
      do_chg(5'h10);
      for (int k = 0; k < 16; k++) begin
         do_psw(1'b0, 4'(k), ~(32'h1010_1010 * k));
         chk("R12 unprivileged masked write", psr_o, exp_psr());
      end
      // R11: saved status words
      do_chg(5'h12);
      do_psw(1'b1, 4'hF, 32'h8765_4321);
      chk("R11 interrupt saved word", spsr_o, exp_spsr());
      do_psw(1'b1, 4'b0101, 32'hFFFF_FFFF);
      chk("R11 saved byte mask", spsr_o, exp_spsr());
      do_chg(5'h13);
      do_psw(1'b1, 4'hF, 32'h0BAD_F00D);
      chk("R11 supervisor saved word", spsr_o, exp_spsr());
      do_chg(5'h1F);
      do_psw(1'b1, 4'hF, 32'hFFFF_FFFF);
      chk("R11 user bank fallback", spsr_o, exp_psr());
      do_chg(5'h0A);
      do_psw(1'b1, 4'hF, 32'hFFFF_FFFF);
      chk("R11 dummy bank fallback", spsr_o, exp_psr());
      do_chg(5'h12);
      chk("R11 interrupt word kept", spsr_o, 32'h8765_4321 | 32'h00FF_00FF);
      check_all("R11 final state");

      done = 1'b1;
      report();
   end
endmodule